// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of a small accumulator machine. On each clock where the load strobe is high, it combines the accumulator with one operand byte, which may come from a register or from memory. A valid operation code then writes the result back into the accumulator and refreshes a five-bit status vector.

The supported operations are:

- addition, with or without the stored carry;
- subtraction, with or without the stored borrow;
- bitwise AND, OR and XOR;
- compare;
- single-step increment and decrement of the accumulator.

The carry used by the carrying forms always comes from the block's own status register. The accumulator and the status vector are plain registers driven straight to the outputs, so a result is visible one clock after the strobe.

The block fits between an instruction decoder, which supplies the operation code and the strobe, and an operand source, which supplies the second byte. Instruction sequencing, decimal adjust, rotates and any bus logic live elsewhere.

Top module: `alu8_core`

## Requirements
- R1: A synchronous active-high reset clears the accumulator to 0x00 and all five status bits to 0.
- R2: When `load` is low, or when `op` holds an unassigned code (10 to 15), the accumulator and the status vector keep their values.
- R3: Code 0 (add) writes A+B into the accumulator, and code 1 (add with carry) writes A+B+C, where C is the stored carry bit; both results are taken modulo 256.
- R4: Code 2 (subtract) writes A−B and code 3 (subtract with borrow) writes A−B−C, both modulo 256. For these codes and for compare, the carry bit becomes 1 exactly when B plus the borrow-in is greater than A.
- R5: Code 7 (compare) sets every status bit as subtract would, and leaves the accumulator unchanged.
- R6: For codes 0 and 1, the carry bit is 1 exactly when the unsigned sum exceeds 255.
- R7: For arithmetic codes, the auxiliary bit is the carry out of bit 3 of the internal addition. For subtraction this addition is A + (~B) + (1 − borrow-in). Increment adds 1 with no other input; decrement is computed as A + 0xFE + 1.
- R8: After any valid operation, the zero bit is 1 exactly when the 8-bit result is 0x00.
- R9: After any valid operation, the sign bit equals bit 7 of the result.
- R10: After any valid operation, the parity bit is 1 when the result holds an even number of ones, and 0 when it holds an odd number.
- R11: Codes 4, 5 and 6 write A AND B, A OR B and A XOR B, and always clear carry. AND sets the auxiliary bit; OR and XOR clear it.
- R12: Code 8 writes A+1 and code 9 writes A−1 (modulo 256). Both update zero, sign, parity and auxiliary, and leave carry unchanged.
- R13: The status vector is laid out as follows:

  | Bit | Flag |
  |-----|------|
  | 4 | sign |
  | 3 | zero |
  | 2 | auxiliary |
  | 1 | parity |
  | 0 | carry |

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Executes the operation on this edge when high |
| op | input | 4 | Operation code (0 to 9 assigned) |
| operand | input | 8 | Second operand byte |
| acc_out | output | 8 | Accumulator contents |
| flags_out | output | 5 | Status vector {sign, zero, aux, parity, carry} |

## Verification
Both the accumulator and the status vector are architectural registers with no pipeline behind them, so any corruption shows at the ports one clock after the offending strobe.

A wrong stored carry is the more insidious case:

- An add or subtract that does not use the carry can look correct while still leaving a wrong carry bit behind.
- That wrong bit then corrupts the result of the next add-with-carry or subtract-with-borrow, possibly many cycles later.
- Increment, decrement and compare also carry or expose state without writing it in the usual way.

For these reasons every flag is compared against an independent model on every clock, over long chains of mixed operations.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int OP_W   = 4;
    localparam int FLAG_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBB = 4'd3,
        OP_AND = 4'd4,
        OP_OR  = 4'd5,
        OP_XOR = 4'd6,
        OP_CMP = 4'd7,
        OP_INC = 4'd8,
        OP_DEC = 4'd9
    } op_e;

    // carry-in source for the adder
    typedef enum logic [1:0] {CIN_ZERO, CIN_ONE, CIN_FLAG, CIN_NFLAG} cin_e;

    // second adder operand source
    typedef enum logic [1:0] {BSEL_OPND, BSEL_ZERO, BSEL_ONE} bsel_e;

    // how the carry flag is updated
    typedef enum logic [1:0] {CY_KEEP, CY_ADD, CY_SUB, CY_CLR} cymode_e;

    // how the auxiliary flag is updated
    typedef enum logic [1:0] {AC_ARITH, AC_SET, AC_CLR} acmode_e;

    typedef enum logic [1:0] {LG_AND, LG_OR, LG_XOR} lgsel_e;

    typedef struct packed {
        logic    valid;
        logic    wr_acc;
        logic    use_logic;
        lgsel_e  lg;
        logic    inv;
        cin_e    cin;
        bsel_e   bsel;
        cymode_e cy;
        acmode_e ac;
    } ctrl_t;

    // first member is the most significant bit of the packed vector
    typedef struct packed {
        logic sign;
        logic zero;
        logic aux;
        logic parity;
        logic carry;
    } flags_t;

    function automatic logic pick_cin(input cin_e sel, input logic stored);
        case (sel)
            CIN_ONE:   return 1'b1;
            CIN_FLAG:  return stored;
            CIN_NFLAG: return ~stored;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/alu8_decode.sv
module alu8_decode
    import alu8_pkg::*;
(
    input  logic [OP_W-1:0] op,
    output ctrl_t           ctrl
);
    always_comb begin
        ctrl           = '0;
        ctrl.lg        = LG_AND;
        ctrl.cin       = CIN_ZERO;
        ctrl.bsel      = BSEL_OPND;
        ctrl.cy        = CY_KEEP;
        ctrl.ac        = AC_ARITH;
        ctrl.valid     = 1'b1;
        ctrl.wr_acc    = 1'b1;
        case (op_e'(op))
            OP_ADD: begin
                ctrl.cy = CY_ADD;
            end
            OP_ADC: begin
                ctrl.cin = CIN_FLAG;
                ctrl.cy  = CY_ADD;
            end
            OP_SUB: begin
                ctrl.inv = 1'b1;
                ctrl.cin = CIN_ONE;
                ctrl.cy  = CY_SUB;
            end
            OP_SBB: begin
                ctrl.inv = 1'b1;
                ctrl.cin = CIN_NFLAG;
                ctrl.cy  = CY_SUB;
            end
            OP_CMP: begin
                ctrl.inv    = 1'b1;
                ctrl.cin    = CIN_ONE;
                ctrl.cy     = CY_SUB;
                ctrl.wr_acc = 1'b0;
            end
            OP_AND: begin
                ctrl.use_logic = 1'b1;
                ctrl.lg        = LG_AND;
                ctrl.cy        = CY_CLR;
                ctrl.ac        = AC_SET;
            end
            OP_OR: begin
                ctrl.use_logic = 1'b1;
                ctrl.lg        = LG_OR;
                ctrl.cy        = CY_CLR;
                ctrl.ac        = AC_CLR;
            end
            OP_XOR: begin
                ctrl.use_logic = 1'b1;
                ctrl.lg        = LG_XOR;
                ctrl.cy        = CY_CLR;
                ctrl.ac        = AC_CLR;
            end
            OP_INC: begin
                ctrl.bsel = BSEL_ZERO;
                ctrl.cin  = CIN_ONE;
            end
            OP_DEC: begin
                ctrl.bsel = BSEL_ONE;
                ctrl.inv  = 1'b1;
                ctrl.cin  = CIN_ONE;
            end
            default: begin
                ctrl.valid  = 1'b0;
                ctrl.wr_acc = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         inv,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         half
);
    localparam int H = W / 2;

    logic [W-1:0] bx;
    logic [W:0]   full;
    logic [H:0]   low;

    always_comb begin
        bx   = inv ? ~b : b;
        full = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, cin};
        low  = {1'b0, a[H-1:0]} + {1'b0, bx[H-1:0]} + {{H{1'b0}}, cin};
        sum  = full[W-1:0];
        cout = full[W];
        half = low[H];
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  lgsel_e       sel,
    output logic [W-1:0] y
);
    always_comb begin
        case (sel)
            LG_OR:   y = a | b;
            LG_XOR:  y = a ^ b;
            default: y = a & b;
        endcase
    end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  ctrl_t        ctrl,
    input  logic [W-1:0] res,
    input  logic         cout,
    input  logic         half,
    input  flags_t       cur,
    output flags_t       nxt
);
    always_comb begin
        nxt = cur;
        if (ctrl.valid) begin
            nxt.zero   = (res == '0);
            nxt.sign   = res[W-1];
            nxt.parity = ~^res;
            case (ctrl.cy)
                CY_ADD:  nxt.carry = cout;
                CY_SUB:  nxt.carry = ~cout;
                CY_CLR:  nxt.carry = 1'b0;
                default: nxt.carry = cur.carry;
            endcase
            case (ctrl.ac)
                AC_SET:  nxt.aux = 1'b1;
                AC_CLR:  nxt.aux = 1'b0;
                default: nxt.aux = half;
            endcase
        end
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [OP_W-1:0]   op,
    input  logic [W-1:0]      operand,
    output logic [W-1:0]      acc_out,
    output logic [FLAG_W-1:0] flags_out
);
    ctrl_t        ctrl;
    flags_t       flags_q;
    flags_t       flags_d;
    logic [W-1:0] acc_q;
    logic [W-1:0] b_sel;
    logic [W-1:0] sum;
    logic [W-1:0] lg_y;
    logic [W-1:0] res;
    logic         cout;
    logic         half;
    logic         cin;

    alu8_decode u_dec (
        .op   (op),
        .ctrl (ctrl)
    );

    always_comb begin
        case (ctrl.bsel)
            BSEL_ZERO: b_sel = '0;
            BSEL_ONE:  b_sel = W'(1);
            default:   b_sel = operand;
        endcase
        cin = pick_cin(ctrl.cin, flags_q.carry);
    end

    alu8_addsub #(.W(W)) u_add (
        .a    (acc_q),
        .b    (b_sel),
        .inv  (ctrl.inv),
        .cin  (cin),
        .sum  (sum),
        .cout (cout),
        .half (half)
    );

    alu8_logic #(.W(W)) u_lg (
        .a   (acc_q),
        .b   (operand),
        .sel (ctrl.lg),
        .y   (lg_y)
    );

    assign res = ctrl.use_logic ? lg_y : sum;

    alu8_flags #(.W(W)) u_flg (
        .ctrl (ctrl),
        .res  (res),
        .cout (cout),
        .half (half),
        .cur  (flags_q),
        .nxt  (flags_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            flags_q <= '0;
        end else if (load) begin
            if (ctrl.wr_acc) acc_q <= res;
            flags_q <= flags_d;
        end
    end

    assign acc_out   = acc_q;
    assign flags_out = flags_q;
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         load,
    input logic [3:0]   op,
    input logic [W-1:0] operand,
    input logic [W-1:0] acc_out,
    input logic [4:0]   flags_out
);
    logic valid_op;
    assign valid_op = (op <= 4'd9);

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!load || !valid_op) |=> ($stable(acc_out) && $stable(flags_out)));

    assert_add_R3: assert property (@(posedge clk) disable iff (rst)
        (load && op == 4'd0) |=> acc_out == W'($past(acc_out) + $past(operand)));

    assert_cmp_keeps_acc_R5: assert property (@(posedge clk) disable iff (rst)
        (load && op == 4'd7) |=> $stable(acc_out));

    assert_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (load && valid_op && op != 4'd7) |=> flags_out[3] == (acc_out == '0));

    assert_sign_R9: assert property (@(posedge clk) disable iff (rst)
        (load && valid_op && op != 4'd7) |=> flags_out[4] == acc_out[W-1]);

    assert_parity_R10: assert property (@(posedge clk) disable iff (rst)
        (load && valid_op && op != 4'd7) |=> flags_out[1] == ~^acc_out);

    assert_logic_carry_R11: assert property (@(posedge clk) disable iff (rst)
        (load && op >= 4'd4 && op <= 4'd6) |=> !flags_out[0]);

    assert_step_carry_R12: assert property (@(posedge clk) disable iff (rst)
        (load && (op == 4'd8 || op == 4'd9)) |=> flags_out[0] == $past(flags_out[0]));
endmodule

bind alu8_core alu8_core_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .op        (op),
    .operand   (operand),
    .acc_out   (acc_out),
    .flags_out (flags_out)
);

// File: tb/alu8_core_test.sv
module alu8_core_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load = 1'b0;
    logic [3:0] op = 4'd0;
    logic [7:0] operand = 8'd0;
    logic [7:0] acc_out;
    logic [4:0] flags_out;

    int total = 0;
    int fails = 0;
    bit done = 0;

    // reference state
    int m_acc, m_cy, m_ac, m_z, m_s, m_p;
    int rng = 32'h1234_5678;

    always #5 clk = ~clk;

    alu8_core uut (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .op        (op),
        .operand   (operand),
        .acc_out   (acc_out),
        .flags_out (flags_out)
    );

    task automatic chk(input string tag, input int act, input int exp, input string what);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_acc = 0; m_cy = 0; m_ac = 0; m_z = 0; m_s = 0; m_p = 0;
    endtask

    task automatic model_step(input int code, input int b);
        int a, c, s, r;
        bit wr, upd;
        a = m_acc; c = m_cy; s = 0; wr = 1; upd = 1;
        case (code)
            0: begin s = a + b; m_cy = (s > 255); m_ac = ((a & 15) + (b & 15)) > 15; end
            1: begin s = a + b + c; m_cy = (s > 255); m_ac = ((a & 15) + (b & 15) + c) > 15; end
            2, 7: begin
                s = a - b; m_cy = (b > a);
                m_ac = ((a & 15) + ((~b) & 15) + 1) > 15;
                wr = (code == 2);
            end
            3: begin s = a - b - c; m_cy = ((b + c) > a); m_ac = ((a & 15) + ((~b) & 15) + (1 - c)) > 15; end
            4: begin s = a & b; m_cy = 0; m_ac = 1; end
            5: begin s = a | b; m_cy = 0; m_ac = 0; end
            6: begin s = a ^ b; m_cy = 0; m_ac = 0; end
            8: begin s = a + 1; m_ac = ((a & 15) == 15); end
            9: begin s = a - 1; m_ac = ((a & 15) != 0); end
            default: upd = 0;
        endcase
        if (upd) begin
            r = s & 255;
            m_z = (r == 0);
            m_s = (r >> 7) & 1;
            m_p = ($countones(r[7:0]) % 2 == 0);
            if (wr) m_acc = r;
        end
    endtask

    task automatic compare_all(input int code, input bit ld);
        string atag;
        string ctag;
        if (!ld || code > 9) atag = "R2";
        else if (code <= 1) atag = "R3";
        else if (code <= 3) atag = "R4";
        else if (code == 7) atag = "R5";
        else if (code <= 6) atag = "R11";
        else atag = "R12";
        ctag = (ld && (code == 2 || code == 3 || code == 7)) ? "R4" : "R6";
        chk(atag, acc_out, m_acc, "accumulator");
        chk(ctag, flags_out[0], m_cy, "carry bit0");
        chk("R7", flags_out[2], m_ac, "aux bit2");
        chk("R8", flags_out[3], m_z, "zero bit3");
        chk("R9", flags_out[4], m_s, "sign bit4");
        chk("R10", flags_out[1], m_p, "parity bit1");
    endtask

    // inputs change only at the falling edge; outputs sampled at the next falling edge
    task automatic step(input bit ld, input int code, input int val);
        load = ld;
        op = 4'(code);
        operand = 8'(val);
        @(posedge clk);
        if (ld) model_step(code, val);
        @(negedge clk);
        compare_all(code, ld);
    endtask

    task automatic set_acc(input int val);
        step(1, 4, 0);      // AND 0 clears acc
        step(1, 0, val);    // ADD value
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog R1: actual cycles 50000 expected run to complete earlier");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 / R13 reset state
        chk("R1", acc_out, 0, "accumulator after reset");
        chk("R13", flags_out, 0, "status vector after reset");

        // R3 / R6 / R7 add cases
        step(1, 0, 8'h0F);
        step(1, 0, 8'h01);          // half carry
        step(1, 0, 8'hF0);          // 0x100 -> zero, carry
        step(1, 1, 8'h00);          // add with carry = 1
        step(1, 1, 8'h7F);          // sign set
        // R4 subtract cases
        set_acc(8'h10);
        step(1, 2, 8'h20);          // borrow
        step(1, 3, 8'h01);          // with borrow-in
        set_acc(8'h05);
        step(1, 2, 8'h05);          // zero, no borrow
        step(1, 3, 8'h05);          // borrow-in 0: 0-5
        // R5 compare
        set_acc(8'h40);
        step(1, 7, 8'h40);
        step(1, 7, 8'h41);
        step(1, 7, 8'h3F);
        // R11 logic
        set_acc(8'hF0);
        step(1, 0, 8'hF0);          // sets carry first
        step(1, 4, 8'h3C);
        step(1, 5, 8'h03);
        step(1, 6, 8'hFF);
        // R12 increment / decrement keep carry
        set_acc(8'hFF);
        step(1, 0, 8'h01);          // acc 0, carry 1
        step(1, 9, 0);              // 0x00 -> 0xFF, carry kept
        step(1, 8, 0);              // 0xFF -> 0x00
        step(1, 8, 0);
        set_acc(8'h0F);
        step(1, 8, 0);              // aux from low nibble
        step(1, 9, 0);
        // R2 no strobe and unassigned codes
        step(0, 0, 8'h55);
        step(0, 4, 8'h00);
        for (int k = 10; k < 16; k++) step(1, k, 8'hA5);
        // R10 parity patterns
        set_acc(8'h03);
        set_acc(8'h07);
        set_acc(8'h80);

        // mixed long chain
        for (int i = 0; i < 600; i++) begin
            rng = rng ^ (rng << 13);
            rng = rng ^ (rng >>> 17);
            rng = rng ^ (rng << 5);
            step(((rng >> 20) & 7) != 0, ((rng >> 8) & 32'h7FFF) % 12, rng & 255);
        end

        // R1 reset from a non-zero state
        set_acc(8'h99);
        step(1, 2, 8'hFF);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        chk("R1", acc_out, 0, "accumulator after second reset");
        chk("R1", flags_out, 0, "status vector after second reset");

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule